// File: doc/BRIEF.md
# Unified Add/Subtract Datapath

This block is the combinational arithmetic core behind every integer add and subtract variant of a 64-bit pipeline: plain add, add with immediate, subtract-from, carrying and extended forms, and the add-to-minus-one and subtract-from-minus-one forms. All of them reduce to one equation, `sum = (I xor A) + B + C`. The decoder selects the variant with three small controls. An invert flag makes `I` all ones or all zeros. A four-way selector picks `B`. A three-way selector picks the carry-in `C`.

Operand A comes from a register read port. When the source index is 0 and the zero-substitution mode is on, A is replaced by zero and the read enable for that port is dropped. The outputs are the 64-bit sum, the carry out of the top bit, and the carry out of bit 31, which the 32-bit modes use. Decode, the register file, overflow and condition-register updates belong to neighbouring blocks.

Top module: `addsub_unit`

## Requirements
- R1: `sum` equals `(I xor A) + B + C` modulo 2^64 for every legal control setting.
- R2: When `srca_zero_mode` is 1 and `srca_idx` is 0, A is zero and `srca_rd_en` is 0. In every other case `srca_rd_en` is 1 and A equals `srca_data`.
- R3: When `inv_a` is 1, I is all ones and A is bitwise inverted before the add. When `inv_a` is 0, I is zero.
- R4: The `b_sel` codes are 0 for `srcb_data`, 1 for the constant 0, 2 for the constant -1 (all ones), and 3 for `imm16` sign-extended from bit 15 to 64 bits.
- R5: The `c_sel` codes are 0 for carry-in 0, 1 for carry-in 1, and 2 for `carry_flag_in`. The reserved code 3 gives carry-in 0.
- R6: `carry_out` is bit 64 of the unsigned 65-bit sum of the three terms.
- R7: `carry_out32` is the carry out of bit 31, which is bit 32 of the unsigned sum of the low 32 bits of the three terms.
- R8: With `inv_a`=1 and `c_sel`=1, `sum` equals B minus A, and `carry_out` is 1 exactly when B >= A (unsigned).
- R9: With `inv_a`=0, `b_sel`=2 and `c_sel`=2, `sum` equals A - 1 + `carry_flag_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srca_idx | input | 5 | Register index of operand A |
| srca_zero_mode | input | 1 | Substitute zero for A when the index is 0 |
| srca_data | input | 64 | Value read for operand A |
| srca_rd_en | output | 1 | Read enable for the operand A port |
| inv_a | input | 1 | Invert operand A (I all ones) |
| srcb_data | input | 64 | Value read for operand B |
| imm16 | input | 16 | Immediate field, signed |
| b_sel | input | 2 | B source: 0 reg, 1 zero, 2 minus one, 3 immediate |
| c_sel | input | 2 | Carry-in source: 0 zero, 1 one, 2 carry flag, 3 zero |
| carry_flag_in | input | 1 | Stored carry bit |
| sum | output | 64 | Result |
| carry_out | output | 1 | Carry out of bit 63 |
| carry_out32 | output | 1 | Carry out of bit 31 |

## Verification
The assertions check on every evaluation that the local stages behave correctly. Zero substitution and its read enable must agree. The B and carry-in selectors must drive the value their code names. Three end-to-end properties must hold: negation, identity, and the subtract-from borrow relation. The assertions cannot show the full arithmetic of the sum and both carries across operands. The bench shows it by sweeping every combination of invert, B code, carry code, carry flag and zero-substitution case against edge and pseudo-random operands. It computes the expected values with wide unsigned arithmetic.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    B_FROM_REG = 2'd0,
    B_ZERO     = 2'd1,
    B_ALL_ONES = 2'd2,
    B_FROM_IMM = 2'd3
  } bsrc_e;

  typedef enum logic [SEL_W-1:0] {
    C_ZERO       = 2'd0,
    C_ONE        = 2'd1,
    C_CARRY_FLAG = 2'd2,
    C_RESERVED   = 2'd3
  } csrc_e;
endpackage

// File: rtl/addsub_opa_stage.sv
module addsub_opa_stage #(
  parameter int unsigned W     = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             zero_mode,
  input  logic [W-1:0]     data,
  input  logic             invert,
  output logic             rd_en,
  output logic [W-1:0]     a_pre,
  output logic [W-1:0]     a_eff
);
  logic idx_is_zero;
  logic substitute;

  assign idx_is_zero = (idx == '0);
  assign substitute  = zero_mode && idx_is_zero;
  assign rd_en       = !substitute;
  assign a_pre       = substitute ? '0 : data;
  // the inversion mask I is a replicated copy of the control bit
  assign a_eff       = a_pre ^ {W{invert}};
endmodule

// File: rtl/addsub_opb_stage.sv
module addsub_opb_stage
  import addsub_pkg::*;
#(
  parameter int unsigned W     = 64,
  parameter int unsigned IMM_W = 16
) (
  input  logic [W-1:0]     reg_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     opb
);
  function automatic logic [W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  bsrc_e sel_e;
  assign sel_e = bsrc_e'(sel);

  always_comb begin
    unique case (sel_e)
      B_FROM_REG: opb = reg_val;
      B_ZERO:     opb = '0;
      B_ALL_ONES: opb = '1;
      B_FROM_IMM: opb = sext_imm(imm);
      default:    opb = '0;
    endcase
  end
endmodule

// File: rtl/addsub_cin_stage.sv
module addsub_cin_stage
  import addsub_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             carry_flag,
  output logic             cin
);
  csrc_e sel_e;
  assign sel_e = csrc_e'(sel);

  always_comb begin
    unique case (sel_e)
      C_ZERO:       cin = 1'b0;
      C_ONE:        cin = 1'b1;
      C_CARRY_FLAG: cin = carry_flag;
      C_RESERVED:   cin = 1'b0;
      default:      cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int unsigned W        = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         carry_narrow
);
  function automatic logic [W:0] wide_add(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic         c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W:0] full;
  assign full      = wide_add(opa, opb, cin);
  assign sum       = full[W-1:0];
  assign carry_out = full[W];

  generate
    if (NARROW_W < W) begin : g_mid_carry
      // carry into bit NARROW_W is recovered from that bit's sum and inputs
      assign carry_narrow = full[NARROW_W] ^ opa[NARROW_W] ^ opb[NARROW_W];
    end else begin : g_top_carry
      assign carry_narrow = full[W];
    end
  endgenerate
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [IDX_W-1:0] srca_idx,
  input  logic             srca_zero_mode,
  input  logic [XLEN-1:0]  srca_data,
  output logic             srca_rd_en,
  input  logic             inv_a,
  input  logic [XLEN-1:0]  srcb_data,
  input  logic [IMM_W-1:0] imm16,
  input  logic [SEL_W-1:0] b_sel,
  input  logic [SEL_W-1:0] c_sel,
  input  logic             carry_flag_in,
  output logic [XLEN-1:0]  sum,
  output logic             carry_out,
  output logic             carry_out32
);
  logic [XLEN-1:0] a_pre;
  logic [XLEN-1:0] a_eff;
  logic [XLEN-1:0] opb_eff;
  logic            cin_eff;

  addsub_opa_stage #(.W(XLEN), .IDX_W(IDX_W)) opa_i (
    .idx       (srca_idx),
    .zero_mode (srca_zero_mode),
    .data      (srca_data),
    .invert    (inv_a),
    .rd_en     (srca_rd_en),
    .a_pre     (a_pre),
    .a_eff     (a_eff)
  );

  addsub_opb_stage #(.W(XLEN), .IMM_W(IMM_W)) opb_i (
    .reg_val (srcb_data),
    .imm     (imm16),
    .sel     (b_sel),
    .opb     (opb_eff)
  );

  addsub_cin_stage cin_i (
    .sel        (c_sel),
    .carry_flag (carry_flag_in),
    .cin        (cin_eff)
  );

  addsub_core #(.W(XLEN), .NARROW_W(NARROW_W)) core_i (
    .opa          (a_eff),
    .opb          (opb_eff),
    .cin          (cin_eff),
    .sum          (sum),
    .carry_out    (carry_out),
    .carry_narrow (carry_out32)
  );
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk
  import addsub_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned IMM_W = 16
) (
  input logic [IDX_W-1:0] srca_idx,
  input logic             srca_zero_mode,
  input logic [XLEN-1:0]  srca_data,
  input logic             srca_rd_en,
  input logic             inv_a,
  input logic [IMM_W-1:0] imm16,
  input logic [SEL_W-1:0] b_sel,
  input logic [SEL_W-1:0] c_sel,
  input logic             carry_flag_in,
  input logic [XLEN-1:0]  sum,
  input logic             carry_out,
  input logic             carry_out32,
  input logic [XLEN-1:0]  a_pre,
  input logic [XLEN-1:0]  opb_eff,
  input logic             cin_eff
);
  always_comb begin
    // R2
    zero_subst_chk: assert ((srca_zero_mode && srca_idx == '0)
                            ? (!srca_rd_en && a_pre == '0)
                            : (srca_rd_en && a_pre == srca_data));
    // R3
    if (inv_a && b_sel == B_ZERO && c_sel == C_ONE)
      negate_chk: assert (sum + a_pre == '0);
    // R4
    if (b_sel == B_ZERO)
      bsel_zero_chk: assert (opb_eff == '0);
    // R4
    if (b_sel == B_ALL_ONES)
      bsel_ones_chk: assert (&opb_eff);
    // R4
    if (b_sel == B_FROM_IMM)
      bsel_imm_chk: assert (opb_eff[IMM_W-1:0] == imm16 &&
                            (opb_eff[XLEN-1:IMM_W-1] == '0 || &opb_eff[XLEN-1:IMM_W-1]) &&
                            opb_eff[XLEN-1] == imm16[IMM_W-1]);
    // R5
    if (c_sel == C_CARRY_FLAG)
      csel_flag_chk: assert (cin_eff == carry_flag_in);
    // R5
    if (c_sel == C_RESERVED)
      csel_rsvd_chk: assert (!cin_eff);
    // R6
    if (!inv_a && b_sel == B_ZERO && c_sel == C_ZERO)
      identity_chk: assert (sum == a_pre && !carry_out);
    // R7
    if (b_sel == B_ZERO && (c_sel == C_ZERO || c_sel == C_RESERVED))
      narrow_nocarry_chk: assert (!carry_out32);
    // R8
    if (inv_a && c_sel == C_ONE)
      subf_borrow_chk: assert (carry_out == (opb_eff >= a_pre));
  end
endmodule

bind addsub_unit addsub_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .IMM_W(IMM_W)) chk_i (
  .srca_idx       (srca_idx),
  .srca_zero_mode (srca_zero_mode),
  .srca_data      (srca_data),
  .srca_rd_en     (srca_rd_en),
  .inv_a          (inv_a),
  .imm16          (imm16),
  .b_sel          (b_sel),
  .c_sel          (c_sel),
  .carry_flag_in  (carry_flag_in),
  .sum            (sum),
  .carry_out      (carry_out),
  .carry_out32    (carry_out32),
  .a_pre          (a_pre),
  .opb_eff        (opb_eff),
  .cin_eff        (cin_eff)
);

// File: tb/addsub_unit_tb_top.sv
module addsub_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NPAT       = 12;

  logic        clk = 1'b0;
  logic [4:0]  srca_idx = '0;
  logic        srca_zero_mode = 1'b0;
  logic [63:0] srca_data = '0;
  logic        srca_rd_en;
  logic        inv_a = 1'b0;
  logic [63:0] srcb_data = '0;
  logic [15:0] imm16 = '0;
  logic [1:0]  b_sel = '0;
  logic [1:0]  c_sel = '0;
  logic        carry_flag_in = 1'b0;
  logic [63:0] sum;
  logic        carry_out;
  logic        carry_out32;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_unit dut_i (
    .srca_idx       (srca_idx),
    .srca_zero_mode (srca_zero_mode),
    .srca_data      (srca_data),
    .srca_rd_en     (srca_rd_en),
    .inv_a          (inv_a),
    .srcb_data      (srcb_data),
    .imm16          (imm16),
    .b_sel          (b_sel),
    .c_sel          (c_sel),
    .carry_flag_in  (carry_flag_in),
    .sum            (sum),
    .carry_out      (carry_out),
    .carry_out32    (carry_out32)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (inv=%0d b=%0d c=%0d ca=%0d)",
               tag, got, exp, inv_a, b_sel, c_sel, carry_flag_in);
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic logic [63:0] edge_val(input int k);
    case (k)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return 64'h0000_0000_FFFF_FFFF;
      5: return 64'h0000_0001_0000_0000;
      default: return 64'h1;
    endcase
  endfunction

  task automatic apply_and_check();
    logic [63:0] a_val, b_val, ia;
    logic        c_val;
    logic [64:0] wide;
    logic [32:0] low;
    bit          subst;
    subst = srca_zero_mode && (srca_idx == 5'd0);
    a_val = subst ? 64'h0 : srca_data;
    case (b_sel)
      2'd0: b_val = srcb_data;
      2'd1: b_val = 64'h0;
      2'd2: b_val = 64'hFFFF_FFFF_FFFF_FFFF;
      default: b_val = {{48{imm16[15]}}, imm16};
    endcase
    case (c_sel)
      2'd1: c_val = 1'b1;
      2'd2: c_val = carry_flag_in;
      default: c_val = 1'b0;
    endcase
    ia   = inv_a ? (64'hFFFF_FFFF_FFFF_FFFF - a_val) : a_val;
    wide = 65'(ia) + 65'(b_val) + 65'(c_val);
    low  = 33'(ia[31:0]) + 33'(b_val[31:0]) + 33'(c_val);
    #1;
    check("R2 rd_en", 64'(srca_rd_en), 64'(!subst));
    check("R1 R3 R4 R5 sum", sum, wide[63:0]);
    check("R6 carry_out", 64'(carry_out), 64'(wide[64]));
    check("R7 carry_out32", 64'(carry_out32), 64'(low[32]));
    if (inv_a && c_sel == 2'd1) begin
      check("R8 diff", sum, b_val - a_val);
      check("R8 borrow", 64'(carry_out), 64'(b_val >= a_val));
    end
    if (!inv_a && b_sel == 2'd2 && c_sel == 2'd2)
      check("R9 minus one form", sum, a_val - 64'd1 + 64'(carry_flag_in));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > WATCHDOG) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // idle state: all-zero inputs give zero result, no carries, port read enabled
    #1;
    check("R1 idle sum", sum, 64'h0);
    check("R6 idle carry", 64'(carry_out), 64'h0);
    check("R7 idle carry32", 64'(carry_out32), 64'h0);
    check("R2 idle rd_en", 64'(srca_rd_en), 64'h1);

    for (int inv = 0; inv < 2; inv++)
      for (int bs = 0; bs < 4; bs++)
        for (int cs = 0; cs < 4; cs++)
          for (int ca = 0; ca < 2; ca++)
            for (int zc = 0; zc < 3; zc++)
              for (int p = 0; p < NPAT; p++) begin
                @(negedge clk);
                inv_a          = inv[0];
                b_sel          = bs[1:0];
                c_sel          = cs[1:0];
                carry_flag_in  = ca[0];
                srca_zero_mode = (zc != 2);
                srca_idx       = (zc == 1) ? 5'd7 : 5'd0;
                if (p < 7) begin
                  srca_data = edge_val(p);
                  srcb_data = edge_val((p + 3) % 7);
                  imm16     = (p[0]) ? 16'h8000 : 16'h7FFF;
                end else begin
                  rng = next_rand(rng); srca_data = rng;
                  rng = next_rand(rng); srcb_data = rng;
                  rng = next_rand(rng); imm16 = rng[15:0];
                end
                apply_and_check();
              end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule